// File: doc/BRIEF.md
# Drive Strength Resolver

This block merges two drivers that share one net into a single resolved drive. It is purely combinational. Each driver is a contiguous range on a 15-point signed position line. Negative positions are strengths on the 0 side, positive positions are strengths on the 1 side, and position 0 is high impedance. A known value at a known strength is a one-point range. An ambiguous drive covers several points. For example, an unknown value at strong strength spans from strong 0 through high impedance to strong 1.

A per-net kind select picks plain resolution, wired-AND, wired-OR, or a net that falls back to a pull level when nothing drives it. Every point of one driver is tested against the weakest point the other driver is sure to have. The result is the smallest range that covers every surviving point. Points weaker than that guaranteed strength are dropped. Points at least as strong are kept. When the kept points lie on opposite sides, the range fills in between them.

The block holds `NETS` independent lanes side by side. More than two drivers are resolved by cascading lanes. There is no clock and no handshake: the outputs follow the inputs in the same cycle.

Top module: `strength_resolver`

## Requirements
- R1: Positions are 4-bit two's complement, from -7 to +7. The magnitude gives the level: 7 supply, 6 strong, 5 pull, 4 large, 3 weak, 2 medium, 1 small, 0 high impedance. A driver is the range [lo, hi] with lo <= hi. The value code is 0 (2'd0) when only negative positions are covered, 1 (2'd1) when only positive, x (2'd2) when both sides are covered, and z (2'd3) for [0,0]. The output range always satisfies lo <= hi.
- R2: Two single-point drivers at different levels resolve to the stronger driver's point.
- R3: In plain mode (kind 3'd0, and kinds 3'd5 to 3'd7, which behave the same), two single points of equal level L with opposite signs give [-L, +L].
- R4: In wired-AND mode (kind 3'd1), an equal-level conflict resolves to the 0-side point. In wired-OR mode (kind 3'd2), it resolves to the 1-side point.
- R5: An ambiguous driver against a single point keeps only its positions whose magnitude is at least that point's level. When all kept positions share the point's sign, the result is their hull together with the point.
- R6: When the kept positions of the ambiguous driver and the single point lie on opposite sides, the result spans from the kept positions to the point, covering everything in between.
- R7: Two ambiguous drivers keep, each against the other, the positions at or above the other's weakest guaranteed level. The result is the hull of the kept positions; for example, [-5,0] merged with [0,3] gives [-5,3].
- R8: Two high-impedance drivers give [0,0] with value z in plain, wired-AND and wired-OR modes.
- R9: When the resolved range would be [0,0], kind 3'd3 outputs [-5,-5] (pull 0) and kind 3'd4 outputs [+5,+5] (pull 1).
- R10: Swapping the two drivers of a lane never changes that lane's outputs.
- R11: Each lane resolves only from its own inputs and kind select, at bit offset lane*4 for ranges, lane*3 for kind and lane*2 for the value code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| net_kind | input | NETS*3 | Per-lane resolution kind select |
| a_lo | input | NETS*4 | Driver A lower position, per lane |
| a_hi | input | NETS*4 | Driver A upper position, per lane |
| b_lo | input | NETS*4 | Driver B lower position, per lane |
| b_hi | input | NETS*4 | Driver B upper position, per lane |
| res_lo | output | NETS*4 | Resolved lower position, per lane |
| res_hi | output | NETS*4 | Resolved upper position, per lane |
| res_val | output | NETS*2 | Resolved value code, per lane |

## Verification
The block holds no state, so any fault in the threshold, survivor or hull logic shows on the outputs in the same cycle as the input pattern that exercises it. A comparison off by one level shows as a range edge one position off, or as a point that should have been dropped still appearing. A wrong wired-mode adjustment shows only on an equal-level conflict of opposite signs. A swap-asymmetric fault shows as a mismatch between two lanes that are driven with the same pair in opposite order. Because the sweep walks every legal pair of ranges under every kind code, each of these faults is hit within the first pass over its input pattern.

// File: rtl/sr_pkg.sv
`timescale 1ns/1ps
package sr_pkg;

  // Per-lane resolution kind codes
  typedef enum logic [2:0] {
    KIND_PLAIN = 3'd0,
    KIND_AND   = 3'd1,
    KIND_OR    = 3'd2,
    KIND_PULL0 = 3'd3,
    KIND_PULL1 = 3'd4
  } net_kind_e;

  // Resolved value codes
  typedef enum logic [1:0] {
    VAL_ZERO = 2'd0,
    VAL_ONE  = 2'd1,
    VAL_X    = 2'd2,
    VAL_Z    = 2'd3
  } net_val_e;

endpackage

// File: rtl/sr_range_probe.sv
`timescale 1ns/1ps
// Reports the weakest level a driver range is guaranteed to have,
// and whether the range lies strictly on one side of high impedance.
module sr_range_probe #(
  parameter int LVL_W = 3,
  localparam int PW = LVL_W + 1,
  localparam int EW = LVL_W + 2
) (
  input  logic signed [PW-1:0] rng_lo,
  input  logic signed [PW-1:0] rng_hi,
  output logic [LVL_W-1:0]     floor_lvl,
  output logic                 neg_only,
  output logic                 pos_only
);
  logic signed [EW-1:0] hi_ext;
  logic signed [EW-1:0] hi_mag;
  logic                 lo_nonpos;
  logic                 hi_nonneg;

  always_comb begin
    hi_ext    = $signed({rng_hi[PW-1], rng_hi});
    hi_mag    = -hi_ext;
    lo_nonpos = rng_lo[PW-1] | (rng_lo == '0);
    hi_nonneg = ~rng_hi[PW-1];
    neg_only  = rng_hi[PW-1];
    pos_only  = ~rng_lo[PW-1] & (rng_lo != '0);
    if (lo_nonpos && hi_nonneg) begin
      floor_lvl = '0;
    end else if (neg_only) begin
      floor_lvl = hi_mag[LVL_W-1:0];
    end else begin
      floor_lvl = rng_lo[LVL_W-1:0];
    end
  end
endmodule

// File: rtl/sr_survivor.sv
`timescale 1ns/1ps
// Keeps the part of one driver's range that the other driver's
// guaranteed strength does not overpower; wired modes bias ties.
module sr_survivor #(
  parameter int LVL_W = 3,
  localparam int PW = LVL_W + 1,
  localparam int EW = LVL_W + 2
) (
  input  logic signed [PW-1:0] own_lo,
  input  logic signed [PW-1:0] own_hi,
  input  logic [LVL_W-1:0]     opp_floor,
  input  logic                 opp_neg_only,
  input  logic                 opp_pos_only,
  input  logic                 wired_and,
  input  logic                 wired_or,
  output logic                 keep,
  output logic signed [PW-1:0] keep_lo,
  output logic signed [PW-1:0] keep_hi
);
  logic signed [EW-1:0] lo_e, hi_e;
  logic signed [EW-1:0] thr_n, thr_p, neg_lim;
  logic signed [EW-1:0] sel_lo, sel_hi;
  logic                 bump_n, bump_p;
  logic                 neg_ok, pos_ok;

  always_comb begin
    lo_e    = $signed({own_lo[PW-1], own_lo});
    hi_e    = $signed({own_hi[PW-1], own_hi});
    // a tie loses on the side the wired function does not favour
    bump_n  = wired_or  & opp_pos_only;
    bump_p  = wired_and & opp_neg_only;
    thr_n   = $signed({2'b00, opp_floor}) + $signed({{(EW-1){1'b0}}, bump_n});
    thr_p   = $signed({2'b00, opp_floor}) + $signed({{(EW-1){1'b0}}, bump_p});
    neg_lim = -thr_n;
    neg_ok  = lo_e <= neg_lim;
    pos_ok  = hi_e >= thr_p;
    if (opp_floor == '0) begin
      keep   = 1'b1;
      sel_lo = lo_e;
      sel_hi = hi_e;
    end else begin
      keep   = neg_ok | pos_ok;
      if (neg_ok)            sel_lo = lo_e;
      else if (lo_e > thr_p) sel_lo = lo_e;
      else                   sel_lo = thr_p;
      if (pos_ok)              sel_hi = hi_e;
      else if (hi_e < neg_lim) sel_hi = hi_e;
      else                     sel_hi = neg_lim;
    end
    keep_lo = sel_lo[PW-1:0];
    keep_hi = sel_hi[PW-1:0];
  end
endmodule

// File: rtl/sr_combine.sv
`timescale 1ns/1ps
// Hull of the two surviving ranges, undriven fallback and value code.
module sr_combine #(
  parameter int LVL_W = 3,
  parameter int PULL_LVL = 5,
  localparam int PW = LVL_W + 1
) (
  input  logic                 keep_a,
  input  logic signed [PW-1:0] a_lo,
  input  logic signed [PW-1:0] a_hi,
  input  logic                 keep_b,
  input  logic signed [PW-1:0] b_lo,
  input  logic signed [PW-1:0] b_hi,
  input  logic                 fill_dn,
  input  logic                 fill_up,
  output logic signed [PW-1:0] r_lo,
  output logic signed [PW-1:0] r_hi,
  output logic [1:0]           r_val
);
  import sr_pkg::*;

  localparam logic [PW-1:0] UP_POS = PW'(PULL_LVL);
  localparam logic [PW-1:0] DN_POS = PW'(-PULL_LVL);

  logic signed [PW-1:0] h_lo, h_hi;
  logic                 neg_side, pos_side;

  always_comb begin
    if (keep_a && keep_b) begin
      h_lo = (a_lo < b_lo) ? a_lo : b_lo;
      h_hi = (a_hi > b_hi) ? a_hi : b_hi;
    end else if (keep_a) begin
      h_lo = a_lo;
      h_hi = a_hi;
    end else if (keep_b) begin
      h_lo = b_lo;
      h_hi = b_hi;
    end else begin
      h_lo = '0;
      h_hi = '0;
    end
    r_lo = h_lo;
    r_hi = h_hi;
    if (h_lo == '0 && h_hi == '0) begin
      if (fill_dn) begin
        r_lo = $signed(DN_POS);
        r_hi = $signed(DN_POS);
      end else if (fill_up) begin
        r_lo = $signed(UP_POS);
        r_hi = $signed(UP_POS);
      end
    end
    neg_side = r_lo[PW-1];
    pos_side = ~r_hi[PW-1] & (r_hi != '0);
    case ({neg_side, pos_side})
      2'b11:   r_val = VAL_X;
      2'b10:   r_val = VAL_ZERO;
      2'b01:   r_val = VAL_ONE;
      default: r_val = VAL_Z;
    endcase
  end
endmodule

// File: rtl/strength_resolver.sv
`timescale 1ns/1ps
module strength_resolver #(
  parameter int LVL_W = 3,
  parameter int NETS = 2,
  parameter int PULL_LVL = 5,
  localparam int PW = LVL_W + 1,
  localparam int KW = 3
) (
  input  logic [NETS*KW-1:0] net_kind,
  input  logic [NETS*PW-1:0] a_lo,
  input  logic [NETS*PW-1:0] a_hi,
  input  logic [NETS*PW-1:0] b_lo,
  input  logic [NETS*PW-1:0] b_hi,
  output logic [NETS*PW-1:0] res_lo,
  output logic [NETS*PW-1:0] res_hi,
  output logic [NETS*2-1:0]  res_val
);
  import sr_pkg::*;

  for (genvar g = 0; g < NETS; g++) begin : g_lane
    logic signed [PW-1:0] al, ah, bl, bh;
    logic signed [PW-1:0] ka_lo, ka_hi, kb_lo, kb_hi;
    logic signed [PW-1:0] rl, rh;
    logic [LVL_W-1:0]     fa, fb;
    logic                 a_neg, a_pos, b_neg, b_pos;
    logic                 ka, kb;
    logic [KW-1:0]        kind;
    logic                 is_and, is_or, is_dn, is_up;
    logic [1:0]           val;

    assign al     = $signed(a_lo[g*PW +: PW]);
    assign ah     = $signed(a_hi[g*PW +: PW]);
    assign bl     = $signed(b_lo[g*PW +: PW]);
    assign bh     = $signed(b_hi[g*PW +: PW]);
    assign kind   = net_kind[g*KW +: KW];
    assign is_and = (kind == KIND_AND);
    assign is_or  = (kind == KIND_OR);
    assign is_dn  = (kind == KIND_PULL0);
    assign is_up  = (kind == KIND_PULL1);

    sr_range_probe #(.LVL_W(LVL_W)) probe_a_i (
      .rng_lo(al), .rng_hi(ah), .floor_lvl(fa), .neg_only(a_neg), .pos_only(a_pos)
    );
    sr_range_probe #(.LVL_W(LVL_W)) probe_b_i (
      .rng_lo(bl), .rng_hi(bh), .floor_lvl(fb), .neg_only(b_neg), .pos_only(b_pos)
    );

    sr_survivor #(.LVL_W(LVL_W)) surv_a_i (
      .own_lo(al), .own_hi(ah), .opp_floor(fb), .opp_neg_only(b_neg),
      .opp_pos_only(b_pos), .wired_and(is_and), .wired_or(is_or),
      .keep(ka), .keep_lo(ka_lo), .keep_hi(ka_hi)
    );
    sr_survivor #(.LVL_W(LVL_W)) surv_b_i (
      .own_lo(bl), .own_hi(bh), .opp_floor(fa), .opp_neg_only(a_neg),
      .opp_pos_only(a_pos), .wired_and(is_and), .wired_or(is_or),
      .keep(kb), .keep_lo(kb_lo), .keep_hi(kb_hi)
    );

    sr_combine #(.LVL_W(LVL_W), .PULL_LVL(PULL_LVL)) comb_i (
      .keep_a(ka), .a_lo(ka_lo), .a_hi(ka_hi),
      .keep_b(kb), .b_lo(kb_lo), .b_hi(kb_hi),
      .fill_dn(is_dn), .fill_up(is_up),
      .r_lo(rl), .r_hi(rh), .r_val(val)
    );

    assign res_lo[g*PW +: PW] = rl;
    assign res_hi[g*PW +: PW] = rh;
    assign res_val[g*2 +: 2]  = val;
  end
endmodule

// File: rtl/sr_checker.sv
`timescale 1ns/1ps
module sr_checker #(
  parameter int LVL_W = 3,
  parameter int NETS = 2,
  parameter int PULL_LVL = 5,
  localparam int PW = LVL_W + 1,
  localparam int KW = 3
) (
  input logic [NETS*KW-1:0] net_kind,
  input logic [NETS*PW-1:0] a_lo,
  input logic [NETS*PW-1:0] a_hi,
  input logic [NETS*PW-1:0] b_lo,
  input logic [NETS*PW-1:0] b_hi,
  input logic [NETS*PW-1:0] res_lo,
  input logic [NETS*PW-1:0] res_hi,
  input logic [NETS*2-1:0]  res_val
);
  localparam int MAXL = (1 << LVL_W) - 1;

  for (genvar g = 0; g < NETS; g++) begin : g_chk
    always_comb begin
      int al, ah, bl, bh, rl, rh, k;
      logic legal, known2;
      al = int'($signed(a_lo[g*PW +: PW]));
      ah = int'($signed(a_hi[g*PW +: PW]));
      bl = int'($signed(b_lo[g*PW +: PW]));
      bh = int'($signed(b_hi[g*PW +: PW]));
      rl = int'($signed(res_lo[g*PW +: PW]));
      rh = int'($signed(res_hi[g*PW +: PW]));
      k  = int'(net_kind[g*KW +: KW]);
      legal  = (al <= ah) && (bl <= bh) && (al >= -MAXL) && (bl >= -MAXL);
      known2 = (al == ah) && (bl == bh) && (al != 0) && (bl != 0);
      if (legal) begin
        // R1
        ordered_span_chk: assert (rl <= rh);
        // R2
        if (known2 && (al * bl < 0) && (al * al > bl * bl))
          known_dominance_chk: assert (rl == al && rh == al);
        // R3
        if (known2 && k == 0 && al == -bl)
          plain_tie_chk: assert (rl == -((al > 0) ? al : -al) && rh == ((al > 0) ? al : -al));
        // R9
        if (k == 3 && al == 0 && ah == 0 && bl == 0 && bh == 0)
          pull_fill_chk: assert (rl == -PULL_LVL && rh == -PULL_LVL);
        // R7
        if (k != 3 && k != 4)
          hull_bound_chk: assert (rl >= ((al < bl) ? al : bl) && rh <= ((ah > bh) ? ah : bh));
      end
    end
  end
endmodule

bind strength_resolver sr_checker #(.LVL_W(LVL_W), .NETS(NETS), .PULL_LVL(PULL_LVL)) chk_i (
  .net_kind(net_kind), .a_lo(a_lo), .a_hi(a_hi), .b_lo(b_lo), .b_hi(b_hi),
  .res_lo(res_lo), .res_hi(res_hi), .res_val(res_val)
);

// File: tb/strength_resolver_tb_top.sv
`timescale 1ns/1ps
module strength_resolver_tb_top;
  localparam int PW = 4;
  localparam int NETS = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NETS*3-1:0]  net_kind = '0;
  logic [NETS*PW-1:0] a_lo = '0, a_hi = '0, b_lo = '0, b_hi = '0;
  logic [NETS*PW-1:0] res_lo, res_hi;
  logic [NETS*2-1:0]  res_val;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  strength_resolver #(.LVL_W(3), .NETS(NETS), .PULL_LVL(5)) dut_i (
    .net_kind(net_kind), .a_lo(a_lo), .a_hi(a_hi), .b_lo(b_lo), .b_hi(b_hi),
    .res_lo(res_lo), .res_hi(res_hi), .res_val(res_val)
  );

  function automatic int iabs(int v);
    return (v < 0) ? -v : v;
  endfunction

  // q overpowers p
  function automatic bit beats(int q, int p, int kind);
    if (iabs(q) > iabs(p)) return 1'b1;
    if (iabs(q) == iabs(p) && q != p) begin
      if (kind == 1 && q < 0 && p > 0) return 1'b1;
      if (kind == 2 && q > 0 && p < 0) return 1'b1;
    end
    return 1'b0;
  endfunction

  task automatic model(input int alo, ahi, blo, bhi, kind, output int rlo, rhi, rv);
    rlo = 99; rhi = -99;
    for (int p = alo; p <= ahi; p++) begin
      bit s = 1'b0;
      for (int q = blo; q <= bhi; q++) if (!beats(q, p, kind)) s = 1'b1;
      if (s) begin if (p < rlo) rlo = p; if (p > rhi) rhi = p; end
    end
    for (int p = blo; p <= bhi; p++) begin
      bit s = 1'b0;
      for (int q = alo; q <= ahi; q++) if (!beats(q, p, kind)) s = 1'b1;
      if (s) begin if (p < rlo) rlo = p; if (p > rhi) rhi = p; end
    end
    if (rlo == 0 && rhi == 0) begin
      if (kind == 3) begin rlo = -5; rhi = -5; end
      if (kind == 4) begin rlo = 5;  rhi = 5;  end
    end
    if (rlo < 0 && rhi > 0) rv = 2;
    else if (rlo < 0)       rv = 0;
    else if (rhi > 0)       rv = 1;
    else                    rv = 3;
  endtask

  function automatic string pick_tag(int alo, ahi, blo, bhi, kind);
    bit ka = (alo == ahi) && (alo != 0);
    bit kb = (blo == bhi) && (blo != 0);
    if (alo == 0 && ahi == 0 && blo == 0 && bhi == 0)
      return (kind == 3 || kind == 4) ? "R9" : "R8";
    if (ka && kb) begin
      if (alo == -blo) return (kind == 1 || kind == 2) ? "R4" : "R3";
      return "R2";
    end
    if (ka || kb) begin
      int k = ka ? alo : blo;
      int ol = ka ? blo : alo;
      int oh = ka ? bhi : ahi;
      if ((k < 0 && oh <= 0) || (k > 0 && ol >= 0)) return "R5";
      return "R6";
    end
    return "R7";
  endfunction

  task automatic check_lane(input int lane, input string tag, input int alo, ahi, blo, bhi,
                            kind, elo, ehi, ev);
    int gl, gh, gv;
    gl = int'($signed(res_lo[lane*PW +: PW]));
    gh = int'($signed(res_hi[lane*PW +: PW]));
    gv = int'(res_val[lane*2 +: 2]);
    checks++;
    if (gl != elo || gh != ehi || gv != ev) begin
      errors++;
      $display("FAIL %s lane %0d kind %0d a=[%0d,%0d] b=[%0d,%0d] actual [%0d,%0d] val %0d expected [%0d,%0d] val %0d",
               tag, lane, kind, alo, ahi, blo, bhi, gl, gh, gv, elo, ehi, ev);
    end
  endtask

  task automatic apply(input int alo, ahi, blo, bhi, kind);
    // lane 0 gets (A,B), lane 1 gets (B,A): R10 and R11
    a_lo = {PW'(blo), PW'(alo)};
    a_hi = {PW'(bhi), PW'(ahi)};
    b_lo = {PW'(alo), PW'(blo)};
    b_hi = {PW'(ahi), PW'(bhi)};
    net_kind = {3'(kind), 3'(kind)};
  endtask

  initial begin
    int elo, ehi, ev;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // idle state: both lanes undriven in plain mode (R8, R1)
    @(negedge clk);
    check_lane(0, "R8", 0, 0, 0, 0, 0, 0, 0, 3);
    check_lane(1, "R8", 0, 0, 0, 0, 0, 0, 0, 3);
    // exhaustive sweep of all legal range pairs under every kind code
    for (int kind = 0; kind < 8; kind++) begin
      for (int alo = -7; alo <= 7; alo++) begin
        for (int ahi = alo; ahi <= 7; ahi++) begin
          for (int blo = -7; blo <= 7; blo++) begin
            for (int bhi = blo; bhi <= 7; bhi++) begin
              @(posedge clk);
              apply(alo, ahi, blo, bhi, kind);
              model(alo, ahi, blo, bhi, kind, elo, ehi, ev);
              @(negedge clk);
              check_lane(0, pick_tag(alo, ahi, blo, bhi, kind), alo, ahi, blo, bhi, kind, elo, ehi, ev);
              check_lane(1, "R10", blo, bhi, alo, ahi, kind, elo, ehi, ev);
            end
          end
        end
      end
    end
    // R7 named case: [-5,0] with [0,3] in plain mode gives [-5,3], value x
    @(posedge clk);
    apply(-5, 0, 0, 3, 0);
    @(negedge clk);
    check_lane(0, "R7", -5, 0, 0, 3, 0, -5, 3, 2);
    // R11: lanes with different kinds resolve independently
    @(posedge clk);
    a_lo = {PW'(-6), PW'(-6)}; a_hi = a_lo;
    b_lo = {PW'(6), PW'(6)};   b_hi = b_lo;
    net_kind = {3'd2, 3'd1};
    @(negedge clk);
    check_lane(0, "R11", -6, -6, 6, 6, 1, -6, -6, 0);
    check_lane(1, "R11", -6, -6, 6, 6, 2, 6, 6, 1);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1900000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual running expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule